// File: doc/BRIEF.md
# Programmable Dual-Modulus Pulse-Swallow Divider

This block models the programmable divide chain of a frequency synthesizer. It runs entirely on the oscillator clock. A two-ratio prescaler divides by P+1 at the start of each output period and by P for the rest of it. A swallow counter decides when the prescaler drops to P, and a main counter decides when the period ends. The total division is N·P + A. A second counter divides a reference stream, supplied as a one-clock enable called `ref_tick`, by R.

The ratio pair is chosen at run time: 32/33 or 64/65. Programmed values outside the legal ranges are forced to the nearest legal value, and a flag reports that this happened. New settings take effect only at the next period boundary, so no period is ever cut short.

A standby input stops all counting. When standby is released, both chains restart from zero.

Top module: `pulse_swallow_div`

## Requirements
- R1: With `pair_sel`=0 (P=32) or `pair_sel`=1 (P=64), consecutive `osc_pulse` pulses are exactly N·P + A clocks apart.
- R2: `mod_hi` (1 = prescaler dividing by P+1) is high for exactly A·(P+1) clocks in each output period, and stays low for the whole period when A=0.
- R3: `osc_pulse` and `ref_pulse` are registered outputs that are each high for exactly one clock per period.
- R4: Consecutive `ref_pulse` pulses are exactly R `ref_tick` pulses apart.
- R5: Out-of-range settings are forced to legal values:
  - N below 5 is used as 5.
  - R below 5 is used as 5.
  - A ≥ N (after N has been forced) is used as N−1.
  - `cfg_err` is 1 one clock after such a setting is applied, and 0 one clock after a legal setting is applied.
- R6: Behaviour around standby (`pwr_save`):
  - While `pwr_save` is 1, no `osc_pulse` or `ref_pulse` appears and `mod_hi` is 0.
  - After `pwr_save` returns to 0, the first `osc_pulse` appears N·P + A clocks later.
- R7: A change to N, A or `pair_sel` made partway through a period leaves that period at its old length. The change applies from the following period on.
- R8: After reset, `osc_pulse`, `ref_pulse` and `cfg_err` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock being divided |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_save | input | 1 | Standby: holds all counters at zero while 1 |
| pair_sel | input | 1 | Ratio pair: 0 selects 32/33, 1 selects 64/65 |
| n_set | input | 11 | Main counter setting N |
| a_set | input | 7 | Swallow counter setting A |
| r_set | input | 14 | Reference divide setting R |
| ref_tick | input | 1 | One-clock enable marking each reference edge |
| osc_pulse | output | 1 | One-clock pulse per divided-oscillator period |
| ref_pulse | output | 1 | One-clock pulse per divided-reference period |
| mod_hi | output | 1 | 1 while the prescaler divides by P+1 |
| cfg_err | output | 1 | 1 when the applied settings were forced into range |

## Verification
On every cycle, the assertions check three things:
- Each output pulse lasts exactly one clock.
- Both outputs and `mod_hi` stay quiet during standby.
- `mod_hi` falls only at a prescaler wrap, and the swallow count is exhausted by the time the main counter ends a period, which also confirms that A is kept below N.

The exact length of each period, the A·(P+1) clocks at the higher ratio, the deferral of settings to the next boundary, and the first-pulse delay after standby can be shown only by the bench scenarios. These scenarios count clocks between pulses under chosen settings.

// File: rtl/sw_div_pkg.sv
package sw_div_pkg;
   localparam int unsigned SWD_N_W   = 11;
   localparam int unsigned SWD_A_W   = 7;
   localparam int unsigned SWD_R_W   = 14;
   localparam int unsigned SWD_N_MIN = 5;
   localparam int unsigned SWD_R_MIN = 5;

   typedef enum logic {
      PAIR_LOW  = 1'b0,
      PAIR_HIGH = 1'b1
   } pair_e;
endpackage

// File: rtl/sw_div_clamp.sv
module sw_div_clamp #(
   parameter int unsigned N_W   = 11,
   parameter int unsigned A_W   = 7,
   parameter int unsigned R_W   = 14,
   parameter int unsigned N_MIN = 5,
   parameter int unsigned R_MIN = 5
) (
   input  logic [N_W-1:0] n_in,
   input  logic [A_W-1:0] a_in,
   input  logic [R_W-1:0] r_in,
   output logic [N_W-1:0] n_out,
   output logic [A_W-1:0] a_out,
   output logic [R_W-1:0] r_out,
   output logic           forced
);
   localparam logic [N_W-1:0] N_LO = N_W'(N_MIN);
   localparam logic [R_W-1:0] R_LO = R_W'(R_MIN);
   localparam int unsigned    CW   = (N_W > A_W) ? N_W : A_W;

   logic          n_low, r_low, a_high;
   logic [CW-1:0] a_wide, n_wide;

   generate
      if (N_MIN < 2) begin : g_bad_nmin
         $error("N_MIN must be at least 2");
      end
      if (R_MIN < 2) begin : g_bad_rmin
         $error("R_MIN must be at least 2");
      end
   endgenerate

   always_comb begin
      n_low  = (n_in < N_LO);
      n_out  = n_low ? N_LO : n_in;
      r_low  = (r_in < R_LO);
      r_out  = r_low ? R_LO : r_in;
      a_wide = CW'(a_in);
      n_wide = CW'(n_out);
      a_high = (a_wide >= n_wide);
      a_out  = a_high ? A_W'(n_wide - CW'(1)) : a_in;
      forced = n_low | r_low | a_high;
   end
endmodule

// File: rtl/sw_div_prescaler.sv
module sw_div_prescaler #(
   parameter int unsigned P_LO = 32,
   parameter int unsigned P_HI = 64
) (
   input  logic clk,
   input  logic rst_n,
   input  logic hold,
   input  logic pair_hi,
   input  logic plus_one,
   output logic wrap
);
   localparam int unsigned PC_W = $clog2(P_HI + 1);

   logic [PC_W-1:0] cnt;
   logic [PC_W-1:0] last;

   generate
      if (P_LO < 2) begin : g_bad_plo
         $error("P_LO must be at least 2");
      end
      if (P_HI <= P_LO) begin : g_bad_phi
         $error("P_HI must exceed P_LO");
      end
   endgenerate

   always_comb begin
      last = pair_hi ? PC_W'(P_HI - 1) : PC_W'(P_LO - 1);
      last = last + PC_W'(plus_one);
      wrap = (cnt == last);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (hold || wrap)
         cnt <= '0;
      else
         cnt <= cnt + PC_W'(1);
   end
endmodule

// File: rtl/sw_div_main.sv
module sw_div_main #(
   parameter int unsigned N_W = 11,
   parameter int unsigned A_W = 7
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           hold,
   input  logic           wrap,
   input  logic [N_W-1:0] act_n,
   input  logic [A_W-1:0] nxt_a,
   output logic           term,
   output logic           plus_one
);
   logic [N_W-1:0] n_cnt;
   logic [A_W-1:0] sw_left;

   always_comb begin
      term     = wrap && (n_cnt == act_n - N_W'(1));
      plus_one = (sw_left != '0);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         n_cnt   <= '0;
         sw_left <= '0;
      end else if (hold || term) begin
         n_cnt   <= '0;
         sw_left <= nxt_a;
      end else if (wrap) begin
         n_cnt <= n_cnt + N_W'(1);
         if (sw_left != '0)
            sw_left <= sw_left - A_W'(1);
      end
   end

   // R2: swallow count is used up before the main count closes the period
   a_r2_swallow_done: assert property (@(posedge clk) disable iff (!rst_n)
      (term && !hold) |-> (sw_left == '0));

   // R2: the prescaler leaves P+1 only on one of its own wraps
   a_r2_drop_on_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(plus_one) && !$past(hold)) |-> $past(wrap));
endmodule

// File: rtl/sw_div_ref.sv
module sw_div_ref #(
   parameter int unsigned R_W = 14
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           hold,
   input  logic           tick,
   input  logic [R_W-1:0] nxt_r,
   output logic           wrap
);
   logic [R_W-1:0] act_r;
   logic [R_W-1:0] r_cnt;

   always_comb wrap = tick && (r_cnt == act_r - R_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         r_cnt <= '0;
         act_r <= '1;
      end else if (hold || wrap) begin
         r_cnt <= '0;
         act_r <= nxt_r;
      end else if (tick) begin
         r_cnt <= r_cnt + R_W'(1);
      end
   end
endmodule

// File: rtl/pulse_swallow_div.sv
module pulse_swallow_div
   import sw_div_pkg::*;
#(
   parameter int unsigned P_LO      = 32,
   parameter int unsigned P_HI      = 64,
   parameter int unsigned N_W       = SWD_N_W,
   parameter int unsigned A_W       = SWD_A_W,
   parameter int unsigned R_W       = SWD_R_W,
   parameter int unsigned N_MIN     = SWD_N_MIN,
   parameter int unsigned R_MIN     = SWD_R_MIN,
   parameter bit          PULSE_REG = 1'b1
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           pwr_save,
   input  logic           pair_sel,
   input  logic [N_W-1:0] n_set,
   input  logic [A_W-1:0] a_set,
   input  logic [R_W-1:0] r_set,
   input  logic           ref_tick,
   output logic           osc_pulse,
   output logic           ref_pulse,
   output logic           mod_hi,
   output logic           cfg_err
);
   logic [N_W-1:0] n_c;
   logic [A_W-1:0] a_c;
   logic [R_W-1:0] r_c;
   logic           forced;
   logic           run_q;
   logic           hold;
   logic [N_W-1:0] act_n;
   pair_e          act_pair;
   logic           pre_wrap;
   logic           term;
   logic           plus_one;
   logic           r_wrap;

   generate
      if (A_W >= N_W) begin : g_bad_aw
         $error("A_W must be narrower than N_W");
      end
   endgenerate

   sw_div_clamp #(
      .N_W(N_W), .A_W(A_W), .R_W(R_W), .N_MIN(N_MIN), .R_MIN(R_MIN)
   ) u_clamp (
      .n_in(n_set), .a_in(a_set), .r_in(r_set),
      .n_out(n_c), .a_out(a_c), .r_out(r_c), .forced(forced)
   );

   always_comb hold = pwr_save | ~run_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q    <= 1'b0;
         act_n    <= N_W'(N_MIN);
         act_pair <= PAIR_LOW;
         cfg_err  <= 1'b0;
      end else begin
         run_q   <= 1'b1;
         cfg_err <= forced;
         if (hold || term) begin
            act_n    <= n_c;
            act_pair <= pair_e'(pair_sel);
         end
      end
   end

   sw_div_prescaler #(.P_LO(P_LO), .P_HI(P_HI)) u_pre (
      .clk(clk), .rst_n(rst_n), .hold(hold),
      .pair_hi(act_pair == PAIR_HIGH), .plus_one(plus_one), .wrap(pre_wrap)
   );

   sw_div_main #(.N_W(N_W), .A_W(A_W)) u_main (
      .clk(clk), .rst_n(rst_n), .hold(hold), .wrap(pre_wrap),
      .act_n(act_n), .nxt_a(a_c), .term(term), .plus_one(plus_one)
   );

   sw_div_ref #(.R_W(R_W)) u_ref (
      .clk(clk), .rst_n(rst_n), .hold(hold), .tick(ref_tick),
      .nxt_r(r_c), .wrap(r_wrap)
   );

   always_comb mod_hi = plus_one & ~hold;

   generate
      if (PULSE_REG) begin : g_pulse_ff
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               osc_pulse <= 1'b0;
               ref_pulse <= 1'b0;
            end else begin
               osc_pulse <= term & ~hold;
               ref_pulse <= r_wrap & ~hold;
            end
         end
      end else begin : g_pulse_comb
         always_comb begin
            osc_pulse = term & ~hold;
            ref_pulse = r_wrap & ~hold;
         end
      end
   endgenerate

   a_r3_osc_single: assert property (@(posedge clk) disable iff (!rst_n)
      osc_pulse |=> !osc_pulse);

   a_r3_ref_single: assert property (@(posedge clk) disable iff (!rst_n)
      ref_pulse |=> !ref_pulse);

   a_r6_quiet_standby: assert property (@(posedge clk) disable iff (!rst_n)
      (pwr_save && $past(pwr_save)) |-> (!osc_pulse && !ref_pulse && !mod_hi));

   a_r5_n_legal: assert property (@(posedge clk) disable iff (!rst_n)
      act_n >= N_W'(N_MIN));
endmodule

// File: tb/tb_pulse_swallow_div.sv
module tb_pulse_swallow_div;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        pwr_save = 1'b0;
   logic        pair_sel = 1'b0;
   logic [10:0] n_set = 11'd10;
   logic [6:0]  a_set = 7'd0;
   logic [13:0] r_set = 14'd7;
   logic        ref_tick = 1'b0;
   logic        osc_pulse, ref_pulse, mod_hi, cfg_err;
   int          tests = 0;
   int          fails = 0;
   int          cyc = 0;

   always #5 clk = ~clk;

   pulse_swallow_div dut (
      .clk(clk), .rst_n(rst_n), .pwr_save(pwr_save), .pair_sel(pair_sel),
      .n_set(n_set), .a_set(a_set), .r_set(r_set), .ref_tick(ref_tick),
      .osc_pulse(osc_pulse), .ref_pulse(ref_pulse), .mod_hi(mod_hi),
      .cfg_err(cfg_err)
   );

   // reference enable: one clock in every three
   initial begin
      forever begin
         @(negedge clk); ref_tick = 1'b0;
         @(negedge clk); ref_tick = 1'b0;
         @(negedge clk); ref_tick = 1'b1;
      end
   end

   initial begin
      forever begin
         @(posedge clk);
         cyc++;
         if (cyc > 190000) begin
            fails++; tests++;
            $display("FAIL watchdog actual=%0d expected<%0d", cyc, 190000);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
         end
      end
   end

   task automatic chk(input string req, input int act, input int exp);
      tests++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wait_osc();
      int g = 0;
      do begin @(negedge clk); g++; end while (!osc_pulse && g < 20000);
   endtask

   // from one osc pulse to the next: length, clocks at P+1, pulse width
   task automatic measure(output int len, output int hi, output int wide);
      hi = mod_hi ? 1 : 0;
      len = 0;
      wide = 1;
      @(negedge clk); len++;
      if (osc_pulse) wide = 2;
      else hi += mod_hi ? 1 : 0;
      while (!osc_pulse && len < 20000) begin
         @(negedge clk); len++;
         if (!osc_pulse) hi += mod_hi ? 1 : 0;
      end
   endtask

   task automatic t_reset();
      chk("R8 osc_pulse after reset", int'(osc_pulse), 0);
      chk("R8 ref_pulse after reset", int'(ref_pulse), 0);
      chk("R8 cfg_err after reset", int'(cfg_err), 0);
   endtask

   task automatic t_period(input bit ps, input int n, input int a);
      int len, hi, wide, p;
      p = ps ? 64 : 32;
      @(negedge clk);
      pair_sel = ps; n_set = 11'(n); a_set = 7'(a);
      wait_osc();
      wait_osc();
      measure(len, hi, wide);
      chk($sformatf("R1 period P=%0d N=%0d A=%0d", p, n, a), len, n*p + a);
      chk($sformatf("R2 P+1 clocks A=%0d", a), hi, a*(p+1));
      chk("R3 osc pulse width", wide, 1);
      chk("R5 cfg_err legal", int'(cfg_err), 0);
   endtask

   task automatic t_ref(input int r, input int exp_ticks, input string tag);
      int g, len;
      @(negedge clk);
      r_set = 14'(r);
      for (int k = 0; k < 2; k++) begin
         g = 0;
         do begin @(negedge clk); g++; end while (!ref_pulse && g < 200000);
      end
      len = 0;
      @(negedge clk); len++;
      chk("R3 ref pulse width", int'(ref_pulse), 0);
      while (!ref_pulse && len < 200000) begin @(negedge clk); len++; end
      chk(tag, len, 3*exp_ticks);
   endtask

   task automatic t_clamp();
      int len, hi, wide;
      @(negedge clk);
      pair_sel = 1'b0; n_set = 11'd3; a_set = 7'd0;
      @(negedge clk); @(negedge clk);
      chk("R5 cfg_err on N<5", int'(cfg_err), 1);
      wait_osc(); wait_osc();
      measure(len, hi, wide);
      chk("R5 N forced to 5", len, 5*32);
      @(negedge clk);
      n_set = 11'd10; a_set = 7'd12;
      @(negedge clk); @(negedge clk);
      chk("R5 cfg_err on A>=N", int'(cfg_err), 1);
      wait_osc(); wait_osc();
      measure(len, hi, wide);
      chk("R5 A forced to N-1", len, 10*32 + 9);
      chk("R5 P+1 clocks with A forced", hi, 9*33);
      @(negedge clk);
      a_set = 7'd4;
      @(negedge clk); @(negedge clk);
      chk("R5 cfg_err cleared", int'(cfg_err), 0);
      t_ref(2, 5, "R5 R forced to 5");
      @(negedge clk); @(negedge clk);
      chk("R5 cfg_err on R<5", int'(cfg_err), 1);
      r_set = 14'd7;
      @(negedge clk); @(negedge clk);
      chk("R5 cfg_err cleared after R", int'(cfg_err), 0);
   endtask

   task automatic t_defer();
      int len, hi, wide;
      @(negedge clk);
      pair_sel = 1'b1; n_set = 11'd10; a_set = 7'd2;
      wait_osc(); wait_osc();
      len = 0;
      repeat (5) begin @(negedge clk); len++; end
      pair_sel = 1'b0; n_set = 11'd12; a_set = 7'd5;
      while (!osc_pulse && len < 20000) begin @(negedge clk); len++; end
      chk("R7 running period keeps old setting", len, 10*64 + 2);
      measure(len, hi, wide);
      chk("R7 next period uses new setting", len, 12*32 + 5);
      chk("R7 P+1 clocks of new setting", hi, 5*33);
   endtask

   task automatic t_standby();
      int seen_osc = 0, seen_ref = 0, seen_mod = 0, len = 0;
      @(negedge clk);
      pair_sel = 1'b0; n_set = 11'd6; a_set = 7'd2;
      wait_osc();
      repeat (40) @(negedge clk);
      pwr_save = 1'b1;
      repeat (300) begin
         @(negedge clk);
         seen_osc += osc_pulse ? 1 : 0;
         seen_ref += ref_pulse ? 1 : 0;
         seen_mod += mod_hi ? 1 : 0;
      end
      chk("R6 no osc pulse in standby", seen_osc, 0);
      chk("R6 no ref pulse in standby", seen_ref, 0);
      chk("R6 mod_hi low in standby", seen_mod, 0);
      pwr_save = 1'b0;
      do begin @(negedge clk); len++; end while (!osc_pulse && len < 20000);
      chk("R6 first pulse after release", len, 6*32 + 2);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_period(1'b0, 5, 0);
      t_period(1'b0, 10, 3);
      t_period(1'b1, 20, 7);
      t_period(1'b1, 37, 0);
      t_period(1'b0, 100, 99);
      t_period(1'b1, 40, 39);
      t_ref(7, 7, "R4 ref period R=7");
      t_ref(20, 20, "R4 ref period R=20");
      t_clamp();
      t_defer();
      t_standby();
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule